// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers thirty-two interrupt inputs and presents one active-low request line to a processor. Each input has its own control word. The control word picks how the input is sensed and gives the input a 3-bit priority. The sensing can be level (high or low) or edge (rising or falling). Two write-only words gate the inputs: one sets enable bits and the other clears them. A status word shows which enabled inputs are pending.

Service runs as a two-step handshake. Software reads the vector word and gets the winning source number times four. That read is the acknowledge: it clears the latched edge of the winner and lets the request line go high. The line stays high until software writes the end-of-service word. After that write, the line drops again if any enabled source is still pending. A separate source-number word reports the current source without any side effect.

The bus is a single-cycle register port. Read data is combinational from the addressed word. Writes, and the side effect of an acknowledge, take effect at the clock edge that ends the access.

Top module: `vpic_top`

## Requirements
- R1: After reset the request line is high, every control word reads 0, the enable vector reads 0, the status word reads 0 and the vector word reads 0.
- R2: The control word of source i is at word address i (0 to 31). Bits 7:6 select the sensing: 0 low level, 1 high level, 2 falling edge, 3 rising edge. Bits 2:0 hold the priority. A read returns only these bits, and every other bit reads 0.
- R3: Writing ones to address 35 sets those enable bits, and reading address 35 returns the enable vector. Writing ones to address 36 clears those enable bits. Zero bits in either write leave the enables unchanged.
- R4: A level source is pending while its input is at the selected level. The input is registered once, so the change becomes visible one clock later. Status (address 34, bit i for source i) is the pending vector ANDed with the enables.
- R5: An edge source latches its pending flag on the selected edge, and the flag stays set after the input returns. The flag is cleared by an acknowledge of that source or by a write to that source's control word.
- R6: Among the enabled pending sources, the highest priority value wins. A tie goes to the lowest source number. A priority-0 source is served only when no other source is pending.
- R7: The request line is low exactly when no interrupt is in service and at least one enabled source is pending.
- R8: A read of address 32 with a pending source and nothing in service returns the winner number times four. That read puts the winner in service and drives the request line high. While a source is in service, the same read returns the in-service number times four and has no side effect.
- R9: Any write to address 37 ends service. The request line then goes low again in the next cycle if an enabled source is pending, and stays high otherwise.
- R10: A read of address 32 with nothing pending and nothing in service returns 0 and changes no state.
- R11: Address 33 returns the current winner number while idle, the in-service number during service, and 0 when idle with nothing pending. Reading it has no side effect.
- R12: If a selected edge arrives on a source in the same cycle as the acknowledge of that source, the new edge is kept as pending.
- R13: Masking a source does not clear its latched edge. Once the source is enabled again it shows as pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Interrupt inputs, bit i is source i |
| bus_sel_i | input | 1 | Bus access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 6 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The clear from an acknowledge and the set from a new edge can land on the same source's pending flag in the same cycle. The bench provokes this on a rising-edge source by raising its input in the clock where the vector read is issued. The bench judges the outcome after the end-of-service write: the status bit must still be set, the request line must be low, and a second acknowledge must return the same vector. The other collisions covered are a masked edge that is kept across a re-enable, and a vector read made while a source is already in service.

// File: rtl/vpic_pkg.sv
`timescale 1ns/1ps
// vpic_pkg: shared sizes, sensing encoding and register addresses for the
// vectored priority interrupt controller. Assumes 32-bit data words.
package vpic_pkg;
    localparam int NSRC   = 32;
    localparam int PRIO_W = 3;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    // Sensing mode held in bits 7:6 of each control word
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_HIGH = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_RISE = 2'd3
    } trig_e;

    localparam logic [ADDR_W-1:0] ADR_VEC    = 6'd32;
    localparam logic [ADDR_W-1:0] ADR_SRCNUM = 6'd33;
    localparam logic [ADDR_W-1:0] ADR_STAT   = 6'd34;
    localparam logic [ADDR_W-1:0] ADR_ENSET  = 6'd35;
    localparam logic [ADDR_W-1:0] ADR_ENCLR  = 6'd36;
    localparam logic [ADDR_W-1:0] ADR_EOS    = 6'd37;

    localparam int TRIG_LSB = 6;
endpackage

// File: rtl/vpic_src_cell.sv
`timescale 1ns/1ps
// vpic_src_cell: per-source sensing. Registers the raw input once, detects
// the selected edge against that register and holds an edge flag. Assumes
// src_i is already synchronous to clk_i. A new edge has precedence over a
// clear in the same cycle.
module vpic_src_cell
    import vpic_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_n_i,
    input  logic  src_i,
    input  trig_e trig_i,
    input  logic  ctl_wr_i,
    input  logic  ack_clr_i,
    output logic  pend_o
);
    logic s_q;
    logic flag_q;
    logic rise, fall, edge_set, edge_clr;

    // Edge detection between the live input and its registered copy
    always_comb begin
        rise     = src_i & ~s_q;
        fall     = ~src_i & s_q;
        edge_set = ((trig_i == TRIG_RISE) && rise) || ((trig_i == TRIG_FALL) && fall);
        edge_clr = ack_clr_i | ctl_wr_i;
    end

    // Input sample and edge flag; a set wins over a clear
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            s_q    <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            s_q <= src_i;
            if (edge_set)      flag_q <= 1'b1;
            else if (edge_clr) flag_q <= 1'b0;
        end
    end

    // Pending selection by sensing mode
    always_comb begin
        unique case (trig_i)
            TRIG_LOW:  pend_o = ~s_q;
            TRIG_HIGH: pend_o = s_q;
            default:   pend_o = flag_q;
        endcase
    end

    a_r5_edge_latch: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (edge_set && !ctl_wr_i && trig_i != TRIG_LOW && trig_i != TRIG_HIGH) |=> flag_q);
    a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (edge_set && ack_clr_i) |=> flag_q);
    a_r4_level_follow: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (trig_i == TRIG_HIGH && src_i) |=> (pend_o || trig_i != TRIG_HIGH));
endmodule

// File: rtl/vpic_arbiter.sv
`timescale 1ns/1ps
// vpic_arbiter: picks the enabled pending source with the highest priority
// value; ties go to the lowest index. Purely combinational; the clock and
// reset feed only its checks.
module vpic_arbiter #(
    parameter int N    = 32,
    parameter int PW   = 3,
    localparam int IDW = $clog2(N)
) (
    input  logic                 clk_i,
    input  logic                 rst_n_i,
    input  logic [N-1:0]         pend_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic                 any_o,
    output logic [IDW-1:0]       win_o
);
    logic [PW-1:0] best;

    // Scan from the top index down so that a tie keeps the lower index
    always_comb begin
        any_o = 1'b0;
        win_o = '0;
        best  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i] && (!any_o || prio_i[i] >= best)) begin
                any_o = 1'b1;
                win_o = IDW'(i);
                best  = prio_i[i];
            end
        end
    end

    a_r6_win_pending: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        any_o |-> pend_i[win_o]);
    a_r6_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !any_o |-> (pend_i == '0));
endmodule

// File: rtl/vpic_top.sv
`timescale 1ns/1ps
// vpic_top: vectored priority interrupt controller. Holds the control words,
// enable vector and service state, decodes the register port and drives the
// active-low request line. Assumes one bus access per cycle and that src_i
// is synchronous to clk_i.
module vpic_top
    import vpic_pkg::*;
#(
    parameter int N    = NSRC,
    localparam int IDW = $clog2(N)
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [N-1:0]      src_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_n_o
);
    typedef enum logic {SVC_IDLE, SVC_BUSY} svc_e;

    logic [N-1:0][1:0]        trig_q;
    logic [N-1:0][PRIO_W-1:0] prio_q;
    logic [N-1:0]             en_q;
    logic [N-1:0]             pend_raw, pend_en, ctl_we, ack_clr;
    svc_e                     svc_q;
    logic [IDW-1:0]           act_q, win_id;
    logic                     any_pend;
    logic                     wr_s, rd_s, ctl_hit, ack_fire, eos_fire;
    logic [IDW-1:0]           ctl_idx;

    // Bus strobe decode
    always_comb begin
        wr_s     = bus_sel_i & bus_wr_i;
        rd_s     = bus_sel_i & ~bus_wr_i;
        ctl_hit  = int'(bus_addr_i) < N;
        ctl_idx  = bus_addr_i[IDW-1:0];
        ack_fire = rd_s && (bus_addr_i == ADR_VEC) && any_pend && (svc_q == SVC_IDLE);
        eos_fire = wr_s && (bus_addr_i == ADR_EOS);
    end

    // Per-source sensing cells with their write and acknowledge strobes
    for (genvar i = 0; i < N; i++) begin : g_src
        assign ctl_we[i]  = wr_s && ctl_hit && (ctl_idx == IDW'(i));
        assign ack_clr[i] = ack_fire && (win_id == IDW'(i));
        vpic_src_cell u_cell (
            .clk_i     (clk_i),
            .rst_n_i   (rst_n_i),
            .src_i     (src_i[i]),
            .trig_i    (trig_e'(trig_q[i])),
            .ctl_wr_i  (ctl_we[i]),
            .ack_clr_i (ack_clr[i]),
            .pend_o    (pend_raw[i])
        );
    end

    assign pend_en = pend_raw & en_q;

    vpic_arbiter #(.N(N), .PW(PRIO_W)) u_arb (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .pend_i  (pend_en),
        .prio_i  (prio_q),
        .any_o   (any_pend),
        .win_o   (win_id)
    );

    // Control words and enable vector
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            trig_q <= '0;
            prio_q <= '0;
            en_q   <= '0;
        end else begin
            if (wr_s && ctl_hit) begin
                trig_q[ctl_idx] <= bus_wdata_i[TRIG_LSB+1:TRIG_LSB];
                prio_q[ctl_idx] <= bus_wdata_i[PRIO_W-1:0];
            end
            if (wr_s && bus_addr_i == ADR_ENSET) en_q <= en_q | bus_wdata_i[N-1:0];
            if (wr_s && bus_addr_i == ADR_ENCLR) en_q <= en_q & ~bus_wdata_i[N-1:0];
        end
    end

    // Service state: acknowledge enters, end-of-service leaves
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            svc_q <= SVC_IDLE;
            act_q <= '0;
        end else begin
            unique case (svc_q)
                SVC_IDLE: if (ack_fire) begin
                    svc_q <= SVC_BUSY;
                    act_q <= win_id;
                end
                SVC_BUSY: if (eos_fire) svc_q <= SVC_IDLE;
                default:  svc_q <= SVC_IDLE;
            endcase
        end
    end

    // Request line from service state and pending set
    assign irq_n_o = ~((svc_q == SVC_IDLE) && any_pend);

    // Read data mux
    always_comb begin
        bus_rdata_o = '0;
        if (ctl_hit) begin
            bus_rdata_o[TRIG_LSB+1:TRIG_LSB] = trig_q[ctl_idx];
            bus_rdata_o[PRIO_W-1:0]          = prio_q[ctl_idx];
        end else begin
            unique case (bus_addr_i)
                ADR_VEC: begin
                    if (svc_q == SVC_BUSY) bus_rdata_o = DATA_W'({act_q, 2'b00});
                    else if (any_pend)     bus_rdata_o = DATA_W'({win_id, 2'b00});
                end
                ADR_SRCNUM: begin
                    if (svc_q == SVC_BUSY) bus_rdata_o = DATA_W'(act_q);
                    else if (any_pend)     bus_rdata_o = DATA_W'(win_id);
                end
                ADR_STAT:  bus_rdata_o = DATA_W'(pend_en);
                ADR_ENSET: bus_rdata_o = DATA_W'(en_q);
                default:   bus_rdata_o = '0;
            endcase
        end
    end

    a_r8_ack_releases: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ack_fire |=> (irq_n_o && svc_q == SVC_BUSY));
    a_r9_eos_ends: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        eos_fire |=> (svc_q == SVC_IDLE));
    a_r10_empty_no_effect: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (rd_s && bus_addr_i == ADR_VEC && !any_pend && svc_q == SVC_IDLE)
            |=> (svc_q == SVC_IDLE && $stable(en_q)));
    a_r3_enable_set: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wr_s && bus_addr_i == ADR_ENSET)
            |=> ((en_q & $past(bus_wdata_i[N-1:0])) == $past(bus_wdata_i[N-1:0])));
endmodule

// File: tb/vpic_top_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: bus_read pushes the expected word, a monitor pops and
// compares it 2 ns after the driving falling edge.
module vpic_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    vpic_top dut_i (
        .clk_i(clk), .rst_n_i(rst_n), .src_i(src), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_n_o(irq_n)
    );

    localparam logic [5:0] VEC = 6'd32, SNUM = 6'd33, STAT = 6'd34,
                           ENS = 6'd35, ENC = 6'd36, EOS = 6'd37;

    // Monitor: compare every read against the scoreboard head
    always @(negedge clk) begin
        #2;
        if (sel && !wr) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: act %h exp none", rdata);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s addr %0d: act %h exp %h", t, addr, rdata, e);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        checks++;
        if (irq_n !== e) begin
            errors++;
            $display("FAIL %s irq_n: act %b exp %b", t, irq_n, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: act running exp finished");
        finish_run();
    end

    initial begin
        repeat (4) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_irq(1'b1, "R1");
        bus_read(ENS, 32'h0, "R1");
        bus_read(6'd4, 32'h0, "R1");
        bus_read(STAT, 32'h0, "R1");
        bus_read(VEC, 32'h0, "R10");
        chk_irq(1'b1, "R10");
        // R2 control word fields
        bus_write(6'd4, 32'hFFFF_FFFF);
        bus_read(6'd4, 32'h0000_00C7, "R2");
        // R3 enable set/clear
        bus_write(ENS, 32'h0000_00F0);
        bus_read(ENS, 32'h0000_00F0, "R3");
        bus_write(ENC, 32'h0000_0030);
        bus_read(ENS, 32'h0000_00C0, "R3");
        bus_write(ENC, 32'hFFFF_FFFF);
        bus_read(ENS, 32'h0, "R3");
        // R4 high level source 6, R7 request line
        bus_write(6'd6, 32'h41);
        bus_write(ENS, 32'h40);
        src[6] = 1'b1; tick();
        bus_read(STAT, 32'h40, "R4");
        chk_irq(1'b0, "R7");
        src[6] = 1'b0; tick();
        bus_read(STAT, 32'h0, "R4");
        chk_irq(1'b1, "R7");
        // R4 low level source 2
        bus_write(6'd2, 32'h02);
        bus_write(ENS, 32'h04);
        bus_read(STAT, 32'h04, "R4");
        src[2] = 1'b1; tick();
        bus_read(STAT, 32'h0, "R4");
        // R6 arbitration, R8 acknowledge, R9 end of service, R11 source number
        bus_write(6'd3, 32'h42);
        bus_write(6'd7, 32'h45);
        bus_write(6'd9, 32'h45);
        bus_write(6'd1, 32'h40);
        bus_write(ENS, 32'h28A);
        src[1] = 1'b1; src[3] = 1'b1; src[7] = 1'b1; src[9] = 1'b1; tick();
        bus_read(SNUM, 32'd7, "R11");
        bus_read(VEC, 32'd28, "R8");
        chk_irq(1'b1, "R8");
        bus_read(SNUM, 32'd7, "R11");
        bus_read(VEC, 32'd28, "R8");
        chk_irq(1'b1, "R8");
        bus_write(EOS, 32'h0);
        chk_irq(1'b0, "R9");
        bus_read(VEC, 32'd28, "R6");
        bus_write(EOS, 32'h0);
        src[7] = 1'b0; tick();
        bus_read(VEC, 32'd36, "R6");
        bus_write(EOS, 32'h0);
        src[9] = 1'b0; tick();
        bus_read(VEC, 32'd12, "R6");
        bus_write(EOS, 32'h0);
        src[3] = 1'b0; tick();
        bus_read(VEC, 32'd4, "R6");
        src[1] = 1'b0; tick();
        bus_write(EOS, 32'h0);
        chk_irq(1'b1, "R9");
        bus_read(VEC, 32'h0, "R10");
        bus_read(SNUM, 32'h0, "R11");
        chk_irq(1'b1, "R10");
        // R5 rising edge latch and clear by acknowledge
        bus_write(6'd12, 32'hC3);
        bus_write(ENS, 32'h1000);
        src[12] = 1'b1; tick();
        src[12] = 1'b0; tick();
        bus_read(STAT, 32'h1000, "R5");
        chk_irq(1'b0, "R5");
        bus_read(VEC, 32'd48, "R5");
        bus_read(STAT, 32'h0, "R5");
        bus_write(EOS, 32'h0);
        chk_irq(1'b1, "R5");
        // R5 falling edge, cleared by control write
        bus_write(6'd13, 32'h83);
        src[13] = 1'b1; tick();
        bus_write(ENS, 32'h2000);
        bus_read(STAT, 32'h0, "R5");
        src[13] = 1'b0; tick();
        bus_read(STAT, 32'h2000, "R5");
        bus_write(6'd13, 32'h83);
        bus_read(STAT, 32'h0, "R5");
        // R13 masked edge kept
        bus_write(ENC, 32'h1000);
        src[12] = 1'b1; tick();
        src[12] = 1'b0; tick();
        bus_read(STAT, 32'h0, "R13");
        chk_irq(1'b1, "R13");
        bus_write(ENS, 32'h1000);
        bus_read(STAT, 32'h1000, "R13");
        chk_irq(1'b0, "R13");
        bus_read(VEC, 32'd48, "R13");
        bus_write(EOS, 32'h0);
        // R12 edge in the same cycle as its acknowledge
        src[12] = 1'b1; tick();
        src[12] = 1'b0; tick();
        src[12] = 1'b1;
        bus_read(VEC, 32'd48, "R12");
        bus_write(EOS, 32'h0);
        bus_read(STAT, 32'h1000, "R12");
        chk_irq(1'b0, "R12");
        bus_read(VEC, 32'd48, "R12");
        bus_write(EOS, 32'h0);
        bus_read(STAT, 32'h0, "R12");
        chk_irq(1'b1, "R12");
        tick(); tick();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: act %0d left exp 0", exp_q.size());
        end
        finish_run();
    end
endmodule